// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver

This block is the receive half of a clock-synchronous serial port. An external serial clock and a data line come into the block. Both pass through a synchronizer into the system clock domain. On each rising edge of the synchronized serial clock, one data bit is shifted into a character register. The first bit received becomes the least significant bit. When a full character has been assembled, it is moved into a holding register and a data-full flag is raised. If the previous character has not yet been acknowledged when a new one completes, the new character is dropped and an overrun flag is raised instead. While the overrun flag is set, the receiver ignores all traffic until software clears that flag.

Software uses a two-address register port. Address 0 is control and status. Address 1 returns the held character. One interrupt-enable bit gates two level interrupt requests: one for data ready and one for receive error.

A small state machine sequences reception. It has four states:
- `RX_OFF`: idle while reception is disabled.
- `RX_INIT`: a single cycle that clears the bit counter and the shift register.
- `RX_SHIFT`: counting bits.
- `RX_HOLD`: frozen by an overrun.

Its transitions are:
- OFF→INIT when enabled.
- INIT→SHIFT.
- SHIFT→HOLD when the overrun flag is seen.
- HOLD→INIT once the flag is cleared.
- Any state→OFF when reception is disabled.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, the control/status register reads 0x00, the data register reads 0x00, and both interrupt outputs are low.
- R2: Serial bits are assembled least significant bit first. Data is sampled at the rising edge of the serial clock, after a two-stage synchronizer. The first bit received lands in bit 0 of the data register (address 1).
- R3: When a character completes while the full flag (status bit 6) is 0, the character is copied to the data register and the full flag becomes 1.
- R4: When a character completes while the full flag is 1, the character is discarded, the data register keeps its value, and the overrun flag (status bit 7) becomes 1.
- R5: While the overrun flag is 1, incoming bits are ignored. The full flag is not set by incoming data and the data register does not change.
- R6: Reception resumes only after software writes 0 to bit 7 at address 0. The next character is then assembled from a fresh bit 0.
- R7: Reading the data register leaves the full flag set. Writing 0 to bit 6 at address 0 clears the flag, and writing 1 to bit 6 has no effect.
- R8: The data interrupt output is high exactly while the full flag and the interrupt enable (bit 1 at address 0) are both 1.
- R9: The error interrupt output is high exactly while the overrun flag and the interrupt enable are both 1.
- R10: While the receive enable (bit 0 at address 0) is 0, serial clock edges are ignored and a partial character is discarded. The data register and both flags keep their values.
- R11: If software clears the full flag in the same cycle that a character completes, the clear takes effect first. The character is accepted, the full flag ends at 1, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | External serial clock |
| sdat_i | input | 1 | Serial data line |
| reg_addr | input | 1 | Register select: 0 control/status, 1 data |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_data_o | output | 1 | Data-ready interrupt request (level) |
| irq_err_o | output | 1 | Receive-error interrupt request (level) |

## Verification
Two events can fall in the same system clock cycle: completion of the eighth bit, and a software write that clears the full flag. The bench lines its control write up with the register-update edge of the last bit. That edge comes three system clock edges after the serial clock rises. The bench then checks that the new character is held, the full flag reads 1 and the overrun flag stays 0. A design that applied the flag check before the clear would show an overrun and the old character instead.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_INIT  = 2'd1,
        RX_SHIFT = 2'd2,
        RX_HOLD  = 2'd3
    } rx_state_e;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_RXEN = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_FULL = 6;
    localparam int unsigned BIT_OVR  = 7;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdat_i,
    output logic sclk_rise,
    output logic sdat_s
);

    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] clk_chain;
    logic [STAGES-1:0] dat_chain;
    logic              clk_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_chain[g] <= 1'b0;
                        dat_chain[g] <= 1'b0;
                    end else begin
                        clk_chain[g] <= sclk_i;
                        dat_chain[g] <= sdat_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_chain[g] <= 1'b0;
                        dat_chain[g] <= 1'b0;
                    end else begin
                        clk_chain[g] <= clk_chain[g-1];
                        dat_chain[g] <= dat_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
        end else begin
            clk_prev <= clk_chain[TOP];
        end
    end

    assign sclk_rise = clk_chain[TOP] & ~clk_prev;
    assign sdat_s    = dat_chain[TOP];

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              frozen,
    input  logic              sclk_rise,
    input  logic              sdat_s,
    output logic              char_done,
    output logic [CHAR_W-1:0] char_data
);

    localparam int unsigned       CNT_W = (CHAR_W > 2) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(CHAR_W - 1);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CHAR_W-1:0] shreg;
    logic              take_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        take_bit  = 1'b0;
        char_done = 1'b0;
        unique case (state_q)
            RX_OFF: begin
                if (rx_en) state_d = RX_INIT;
            end
            RX_INIT: begin
                if (!rx_en)      state_d = RX_OFF;
                else if (frozen) state_d = RX_HOLD;
                else             state_d = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (!rx_en) begin
                    state_d = RX_OFF;
                end else if (frozen) begin
                    state_d = RX_HOLD;
                end else if (sclk_rise) begin
                    take_bit  = 1'b1;
                    char_done = (bit_cnt == LAST);
                end
            end
            RX_HOLD: begin
                if (!rx_en)       state_d = RX_OFF;
                else if (!frozen) state_d = RX_INIT;
            end
            default: state_d = RX_OFF;
        endcase
    end

    assign char_data = {sdat_s, shreg[CHAR_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (state_q != RX_SHIFT) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (take_bit) begin
            shreg   <= char_data;
            bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import srx_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              rx_en,
    output logic              irq_en,
    output logic              full,
    output logic              ovr,
    output logic [CHAR_W-1:0] rx_data,
    output logic              irq_data,
    output logic              irq_err
);

    logic ctrl_wr;
    logic full_clr;
    logic ovr_clr;
    logic full_after_clr;
    logic accept;
    logic overrun_hit;
    logic unused_wbits;

    assign ctrl_wr        = reg_wr && (reg_addr == ADDR_CTRL);
    assign full_clr       = ctrl_wr && !reg_wdata[BIT_FULL];
    assign ovr_clr        = ctrl_wr && !reg_wdata[BIT_OVR];
    assign full_after_clr = full && !full_clr;
    assign accept         = char_done && !ovr && !full_after_clr;
    assign overrun_hit    = char_done && !ovr && full_after_clr;
    assign unused_wbits   = ^reg_wdata[BIT_FULL-1:BIT_IE+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en  <= 1'b0;
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            rx_en  <= reg_wdata[BIT_RXEN];
            irq_en <= reg_wdata[BIT_IE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
        end else if (full_clr) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (overrun_hit) begin
            ovr <= 1'b1;
        end else if (ovr_clr) begin
            ovr <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (accept) begin
            rx_data <= char_data;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[BIT_RXEN] = rx_en;
            reg_rdata[BIT_IE]   = irq_en;
            reg_rdata[BIT_FULL] = full;
            reg_rdata[BIT_OVR]  = ovr;
        end else begin
            reg_rdata[CHAR_W-1:0] = rx_data;
        end
    end

    assign irq_data = full & irq_en;
    assign irq_err  = ovr & irq_en;

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import srx_pkg::*;
#(
    parameter int unsigned CHAR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       sdat_i,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_data_o,
    output logic       irq_err_o
);

    logic              sclk_rise;
    logic              sdat_s;
    logic              rx_en;
    logic              irq_en;
    logic              full;
    logic              ovr;
    logic              char_done;
    logic [CHAR_W-1:0] char_data;
    logic [CHAR_W-1:0] rx_data;

    srx_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .sdat_i    (sdat_i),
        .sclk_rise (sclk_rise),
        .sdat_s    (sdat_s)
    );

    srx_shifter #(
        .CHAR_W (CHAR_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .frozen    (ovr),
        .sclk_rise (sclk_rise),
        .sdat_s    (sdat_s),
        .char_done (char_done),
        .char_data (char_data)
    );

    srx_regs #(
        .CHAR_W (CHAR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (char_done),
        .char_data (char_data),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_en     (rx_en),
        .irq_en    (irq_en),
        .full      (full),
        .ovr       (ovr),
        .rx_data   (rx_data),
        .irq_data  (irq_data_o),
        .irq_err   (irq_err_o)
    );

endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic              full,
    input logic              ovr,
    input logic              char_done,
    input logic [CHAR_W-1:0] rx_data,
    input logic              irq_data,
    input logic              irq_err,
    input logic              reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata
);

    logic clr_full_req;
    assign clr_full_req = reg_wr && (reg_addr == ADDR_CTRL) && !reg_wdata[BIT_FULL];

    // R8
    irq_data_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && irq_en) |-> irq_data);

    // R8
    irq_data_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full || !irq_en) |-> !irq_data);

    // R9
    irq_err_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && irq_en) |-> irq_err);

    // R4
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(full) && $past(char_done)));

    // R5
    frozen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> $stable(rx_data));

    // R5
    frozen_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> !char_done);

    // R3
    data_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> full);

    // R7
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(clr_full_req));

endmodule

bind sync_serial_rx srx_checker #(
    .CHAR_W (CHAR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (irq_en),
    .full      (full),
    .ovr       (ovr),
    .char_done (char_done),
    .rx_data   (rx_data),
    .irq_data  (irq_data_o),
    .irq_err   (irq_err_o),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata)
);

// File: tb/test_sync_serial_rx.sv
module test_sync_serial_rx;

    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC      = 8;
    localparam logic [7:0] VECS [N_VEC] = '{
        8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C, 8'h5A, 8'hC3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_i = 1'b0;
    logic       sdat_i = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_data_o;
    logic       irq_err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_serial_rx i_sync_serial_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk_i),
        .sdat_i     (sdat_i),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_data_o (irq_data_o),
        .irq_err_o  (irq_err_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_addr  = 1'b0;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // one serial bit; optional control write on the register-update edge
    task automatic send_bit(input logic b, input bit clr, input logic [7:0] cv);
        @(negedge clk);
        sclk_i = 1'b0;
        sdat_i = b;
        repeat (4) @(negedge clk);
        sclk_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (clr) begin
            reg_addr  = 1'b0;
            reg_wdata = cv;
            reg_wr    = 1'b1;
        end
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        sclk_i = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] c);
        for (int i = 0; i < 8; i++) send_bit(c[i], 1'b0, 8'h00);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_status(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd(1'b0, v);
        check(tag, v, exp);
    endtask

    task automatic check_data(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd(1'b1, v);
        check(tag, v, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_status("R1 status", 8'h00);
        check_data("R1 data", 8'h00);
        check("R1 irqs", {6'd0, irq_err_o, irq_data_o}, 8'h00);

        wr_ctrl(8'hC3);
        repeat (4) @(negedge clk);

        // R2 R3 R7 R8 table of characters
        for (int k = 0; k < N_VEC; k++) begin
            send_char(VECS[k]);
            check_data("R2 lsb-first char", VECS[k]);
            check_status("R3 full set", 8'h43);
            check("R8 irq_data high", {7'd0, irq_data_o}, 8'h01);
            check_status("R7 read keeps full", 8'h43);
            wr_ctrl(8'hC3);
            check_status("R7 write one no effect", 8'h43);
            wr_ctrl(8'h83);
            check_status("R7 write zero clears", 8'h03);
            check("R8 irq_data low", {7'd0, irq_data_o}, 8'h00);
        end

        // R4 overrun
        send_char(8'h6E);
        send_char(8'h91);
        check_data("R4 data kept", 8'h6E);
        check_status("R4 overrun set", 8'hC3);
        check("R9 irq_err high", {7'd0, irq_err_o}, 8'h01);

        // R5 frozen
        wr_ctrl(8'h83);
        send_char(8'h2B);
        check_status("R5 full not set", 8'h83);
        check_data("R5 data unchanged", 8'h6E);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, 8'h00);
        wr_ctrl(8'h81);
        check("R9 irq_err gated", {7'd0, irq_err_o}, 8'h00);

        // R6 resume after clearing overrun
        wr_ctrl(8'h43);
        check_status("R6 overrun cleared", 8'h03);
        repeat (4) @(negedge clk);
        send_char(8'hD4);
        check_data("R6 fresh char", 8'hD4);
        check_status("R6 full after resume", 8'h43);

        // R10 disable discards partial, keeps state
        wr_ctrl(8'h83);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, 8'h00);
        wr_ctrl(8'hC2);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0, 8'h00);
        check_status("R10 disabled idle", 8'h02);
        check_data("R10 data kept", 8'hD4);
        wr_ctrl(8'hC3);
        repeat (4) @(negedge clk);
        send_char(8'h17);
        check_data("R10 clean restart", 8'h17);
        wr_ctrl(8'hC2);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 8'h00);
        check_status("R10 flags kept", 8'h42);
        check_data("R10 data kept full", 8'h17);
        wr_ctrl(8'hC3);
        repeat (4) @(negedge clk);

        // R11 clear full on the completing edge
        for (int i = 0; i < 7; i++) send_bit(logic'((8'hB6 >> i) & 1), 1'b0, 8'h00);
        send_bit(1'b1, 1'b1, 8'h83);
        repeat (4) @(negedge clk);
        check_data("R11 char accepted", 8'hB6);
        check_status("R11 full no overrun", 8'h43);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule